// File: doc/BRIEF.md
# Floating-point exception status updater

This block holds the sticky exception state of a floating-point status and control register. One completed operation per cycle reports its exception indications: eight invalid-operation causes, zero divide, overflow, a tiny result with a separate loss-of-accuracy qualifier, and an inexact result. The block merges these into sticky flags that stay set until software rewrites them. It keeps an overall summary bit that records new exceptions, a read-only invalid summary and an enabled-exception summary.

In the same cycle as the operation arrives, the block tells the writeback stage whether the destination write must be cancelled. It also says whether a quiet NaN is to be delivered, which goes with an unordered condition code. When the enabled-exception summary turns on, it raises a one-cycle request toward the trap logic, unless the mode input selects ignore-exceptions. A software port rewrites the flags, the enables and the overall summary in one access. Rounding, arithmetic, result formatting and interrupt delivery belong to other blocks.

Top module: `fpx_status_unit`

## Requirements
- R1: While `rst_n` is low, every bit of `stat_o` is 0, and `handler_req_o` is 0.
- R2: Sticky flags sit in `stat_o[12:0]`. Bits [7:0] are the operation invalid causes in the order of `op_inv_i`: [0] signalling NaN, [1] inf−inf, [2] inf÷inf, [3] 0÷0, [4] inf×0, [5] invalid compare, [6] invalid square root, [7] invalid integer convert. Bit [8] is the software-requested invalid. Bits [9] zero divide, [10] overflow, [11] underflow and [12] inexact follow. A flag set by an operation with `op_valid_i` high stays set until a software write clears it.
- R3: The overall summary `stat_o[18]` becomes 1 at an edge where any flag bit goes from 0 in the held register to 1. It also becomes 1 when software writes it as 1. Setting a flag that is already 1 leaves it unchanged.
- R4: The invalid summary `stat_o[19]` is the OR of flags [8:0]. It has no bit in `sw_wdata_i` and so cannot be written.
- R5: The enabled summary `stat_o[20]` is 1 when any class flag is 1 together with its enable. The pairs are: invalid summary with `stat_o[13]`, zero divide with [14], overflow with [15], underflow with [16], and inexact with [17].
- R6: `suppress_o` is combinational. It is 1 when `op_valid_i` is high and either some `op_inv_i` bit is set with the invalid enable held at 1, or `op_zdiv_i` is set with the zero-divide enable held at 1.
- R7: `default_nan_o` is combinational. It is 1 when `op_valid_i` and `op_is_arith_i` are high, some `op_inv_i` bit is set, and the invalid enable is held at 0.
- R8: Underflow is flagged for a valid operation with `op_tiny_i` set when the held underflow enable is 1. When that enable is 0, `op_loss_i` must also be set.
- R9: `op_ovf_i` sets the overflow flag. Inexact is flagged when `op_inexact_i` is set, or when `op_ovf_i` is set while the held overflow enable is 0.
- R10: When `sw_we_i` is high, the next edge loads `stat_o[18:0]` from `sw_wdata_i`, using the same bit layout. Flags from an operation in that cycle are ORed on top. The enables that decide R6 to R9 are the values held before the edge.
- R11: `handler_req_o` is 1 for exactly the one cycle after an edge at which the enabled summary goes from 0 to 1, provided `mode_i` was not 0 in the update cycle. Mode 0 means ignore exceptions.
- R12: A single operation may set several flags together, for example signalling NaN with invalid integer convert, or overflow with inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Handler mode, 0 = ignore exceptions |
| op_valid_i | input | 1 | A completed operation reports this cycle |
| op_is_arith_i | input | 1 | Operation is arithmetic or round-to-single |
| op_inv_i | input | 8 | Invalid-operation causes |
| op_zdiv_i | input | 1 | Zero divide occurred |
| op_ovf_i | input | 1 | Overflow occurred |
| op_tiny_i | input | 1 | Intermediate result is tiny |
| op_loss_i | input | 1 | Loss of accuracy on a tiny result |
| op_inexact_i | input | 1 | Rounded result differs from the exact one |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 19 | Software image: flags, enables, overall summary |
| stat_o | output | 21 | Register view: flags, enables, summaries |
| suppress_o | output | 1 | Cancel the destination write |
| default_nan_o | output | 1 | Deliver a quiet NaN and an unordered code |
| handler_req_o | output | 1 | One-cycle trap request |

## Verification
The assertions check on every cycle the rules that hold in any state. Flags and enables do not change without a software write, except that flags may be set. A newly set flag always brings the overall summary with it. The cancel output is tied to the enables held for invalid and zero-divide operations. A handler request lasts one cycle, needs the enabled summary, and never follows ignore mode. The scenarios are needed for the rest, because that depends on the sequence of writes and operations. This covers the enable-dependent underflow and inexact rules, an already-set flag that leaves a cleared summary at 0, and a software write merged with an operation in the same cycle. It also covers the quiet-NaN case and a request that depends on the summary rising rather than merely being set.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int N_OP_INV  = 8;
  localparam int N_INV     = N_OP_INV + 1;
  localparam int N_FLAG    = N_INV + 4;
  localparam int N_EN      = 5;
  localparam int WR_W      = N_FLAG + N_EN + 1;
  localparam int ST_W      = WR_W + 2;
  localparam int MODE_W    = 2;
  // flag positions
  localparam int B_SOFT    = N_OP_INV;
  localparam int B_ZD      = N_INV;
  localparam int B_OV      = N_INV + 1;
  localparam int B_UN      = N_INV + 2;
  localparam int B_NX      = N_INV + 3;
  // enable positions inside the enable vector
  localparam int E_INV     = 0;
  localparam int E_ZD      = 1;
  localparam int E_OV      = 2;
  localparam int E_UN      = 3;
  localparam int E_NX      = 4;
  // positions in the register view
  localparam int S_EN_LO   = N_FLAG;
  localparam int S_FX      = N_FLAG + N_EN;
  localparam int S_VX      = S_FX + 1;
  localparam int S_FEX     = S_FX + 2;
  localparam logic [MODE_W-1:0] MODE_IGNORE = '0;
endpackage

// File: rtl/fpx_cause_eval.sv
module fpx_cause_eval
  import fpx_pkg::*;
(
  input  logic                op_valid,
  input  logic                op_is_arith,
  input  logic [N_OP_INV-1:0] op_inv,
  input  logic                op_zdiv,
  input  logic                op_ovf,
  input  logic                op_tiny,
  input  logic                op_loss,
  input  logic                op_inexact,
  input  logic                en_inv,
  input  logic                en_zd,
  input  logic                en_ov,
  input  logic                en_un,
  output logic [N_FLAG-1:0]   occ,
  output logic                suppress,
  output logic                default_nan
);
  logic any_inv;

  always_comb begin
    any_inv = |op_inv;
    occ     = '0;
    if (op_valid) begin
      occ[N_OP_INV-1:0] = op_inv;
      occ[B_ZD]         = op_zdiv;
      occ[B_OV]         = op_ovf;
      // tiny alone counts only when the trap is enabled
      occ[B_UN]         = op_tiny & (en_un | op_loss);
      // disabled overflow delivers an inexact result
      occ[B_NX]         = op_inexact | (op_ovf & ~en_ov);
    end
    suppress    = op_valid & ((any_inv & en_inv) | (op_zdiv & en_zd));
    default_nan = op_valid & op_is_arith & any_inv & ~en_inv;
  end
endmodule

// File: rtl/fpx_sticky_reg.sv
module fpx_sticky_reg
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FLAG-1:0] occ,
  input  logic              sw_we,
  input  logic [WR_W-1:0]   sw_wdata,
  output logic [N_FLAG-1:0] flags_q,
  output logic [N_EN-1:0]   en_q,
  output logic              fx_q,
  output logic [N_FLAG-1:0] flags_d,
  output logic [N_EN-1:0]   en_d
);
  logic [N_FLAG-1:0] base_flags;
  logic              base_fx;
  logic              fx_d;
  logic              upd;

  // next-state
  always_comb begin
    base_flags = sw_we ? sw_wdata[N_FLAG-1:0]       : flags_q;
    en_d       = sw_we ? sw_wdata[S_EN_LO+:N_EN]    : en_q;
    base_fx    = sw_we ? sw_wdata[S_FX]             : fx_q;
    flags_d    = base_flags | occ;
    fx_d       = base_fx | (|(flags_d & ~flags_q));
    upd        = sw_we | (|occ);
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      fx_q    <= 1'b0;
    end else if (upd) begin
      flags_q <= flags_d;
      en_q    <= en_d;
      fx_q    <= fx_d;
    end
  end
endmodule

// File: rtl/fpx_summary.sv
module fpx_summary
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [N_FLAG-1:0] flags_q,
  input  logic [N_EN-1:0]   en_q,
  input  logic [N_FLAG-1:0] flags_d,
  input  logic [N_EN-1:0]   en_d,
  output logic              vx,
  output logic              fex,
  output logic              handler_req
);
  logic [N_EN-1:0] cls_now;
  logic [N_EN-1:0] cls_nxt;
  logic            fex_nxt;
  logic            req_d;
  logic            req_q;

  assign cls_now[E_INV] = |flags_q[N_INV-1:0];
  assign cls_nxt[E_INV] = |flags_d[N_INV-1:0];

  genvar gi;
  generate
    for (gi = 1; gi < N_EN; gi++) begin : g_cls
      assign cls_now[gi] = flags_q[N_INV+gi-1];
      assign cls_nxt[gi] = flags_d[N_INV+gi-1];
    end
  endgenerate

  always_comb begin
    vx      = cls_now[E_INV];
    fex     = |(cls_now & en_q);
    fex_nxt = |(cls_nxt & en_d);
    req_d   = fex_nxt & ~fex & (mode != MODE_IGNORE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign handler_req = req_q;
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic                op_valid_i,
  input  logic                op_is_arith_i,
  input  logic [N_OP_INV-1:0] op_inv_i,
  input  logic                op_zdiv_i,
  input  logic                op_ovf_i,
  input  logic                op_tiny_i,
  input  logic                op_loss_i,
  input  logic                op_inexact_i,
  input  logic                sw_we_i,
  input  logic [WR_W-1:0]     sw_wdata_i,
  output logic [ST_W-1:0]     stat_o,
  output logic                suppress_o,
  output logic                default_nan_o,
  output logic                handler_req_o
);
  logic [N_FLAG-1:0] occ;
  logic [N_FLAG-1:0] flags_q;
  logic [N_FLAG-1:0] flags_d;
  logic [N_EN-1:0]   en_q;
  logic [N_EN-1:0]   en_d;
  logic              fx_q;
  logic              vx;
  logic              fex;

  fpx_cause_eval u_cause (
    .op_valid    (op_valid_i),
    .op_is_arith (op_is_arith_i),
    .op_inv      (op_inv_i),
    .op_zdiv     (op_zdiv_i),
    .op_ovf      (op_ovf_i),
    .op_tiny     (op_tiny_i),
    .op_loss     (op_loss_i),
    .op_inexact  (op_inexact_i),
    .en_inv      (en_q[E_INV]),
    .en_zd       (en_q[E_ZD]),
    .en_ov       (en_q[E_OV]),
    .en_un       (en_q[E_UN]),
    .occ         (occ),
    .suppress    (suppress_o),
    .default_nan (default_nan_o)
  );

  fpx_sticky_reg u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .occ      (occ),
    .sw_we    (sw_we_i),
    .sw_wdata (sw_wdata_i),
    .flags_q  (flags_q),
    .en_q     (en_q),
    .fx_q     (fx_q),
    .flags_d  (flags_d),
    .en_d     (en_d)
  );

  fpx_summary u_summary (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_i),
    .flags_q     (flags_q),
    .en_q        (en_q),
    .flags_d     (flags_d),
    .en_d        (en_d),
    .vx          (vx),
    .fex         (fex),
    .handler_req (handler_req_o)
  );

  assign stat_o = {fex, vx, fx_q, en_q, flags_q};
endmodule

// File: rtl/fpx_status_unit_chk.sv
module fpx_status_unit_chk
  import fpx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [MODE_W-1:0]   mode_i,
  input logic                op_valid_i,
  input logic [N_OP_INV-1:0] op_inv_i,
  input logic                op_zdiv_i,
  input logic                sw_we_i,
  input logic [ST_W-1:0]     stat_o,
  input logic                suppress_o,
  input logic                handler_req_o
);
  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we_i |=> ((stat_o[N_FLAG-1:0] & $past(stat_o[N_FLAG-1:0])) == $past(stat_o[N_FLAG-1:0])));

  // R3
  summary_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we_i |=> (((stat_o[N_FLAG-1:0] & ~$past(stat_o[N_FLAG-1:0])) == '0) || stat_o[S_FX]));

  // R10
  enable_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we_i |=> $stable(stat_o[S_EN_LO+:N_EN]));

  // R6
  suppress_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && (|op_inv_i) && stat_o[S_EN_LO+E_INV]) |-> suppress_o);

  // R6
  suppress_zd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_zdiv_i && stat_o[S_EN_LO+E_ZD]) |-> suppress_o);

  // R6
  suppress_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_o |-> op_valid_i);

  // R11
  req_needs_fex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handler_req_o |-> stat_o[S_FEX]);

  // R11
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handler_req_o |=> !handler_req_o);

  // R11
  req_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_IGNORE) |=> !handler_req_o);
endmodule

bind fpx_status_unit fpx_status_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .op_valid_i    (op_valid_i),
  .op_inv_i      (op_inv_i),
  .op_zdiv_i     (op_zdiv_i),
  .sw_we_i       (sw_we_i),
  .stat_o        (stat_o),
  .suppress_o    (suppress_o),
  .handler_req_o (handler_req_o)
);

// File: tb/fpx_status_unit_bench.sv
module fpx_status_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        op_valid_i, op_is_arith_i;
  logic [7:0]  op_inv_i;
  logic        op_zdiv_i, op_ovf_i, op_tiny_i, op_loss_i, op_inexact_i;
  logic        sw_we_i;
  logic [18:0] sw_wdata_i;
  logic [20:0] stat_o;
  logic        suppress_o, default_nan_o, handler_req_o;

  int vectors = 0;
  int fails   = 0;

  // reference state
  logic [12:0] m_flags;
  logic [4:0]  m_en;
  logic        m_fx;

  logic [20:0] q_stat[$];
  logic        q_req[$];
  string       q_tag[$];

  fpx_status_unit u_fpx_status_unit (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .op_valid_i(op_valid_i), .op_is_arith_i(op_is_arith_i), .op_inv_i(op_inv_i),
    .op_zdiv_i(op_zdiv_i), .op_ovf_i(op_ovf_i), .op_tiny_i(op_tiny_i),
    .op_loss_i(op_loss_i), .op_inexact_i(op_inexact_i),
    .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
    .stat_o(stat_o), .suppress_o(suppress_o), .default_nan_o(default_nan_o),
    .handler_req_o(handler_req_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic fex_of(input logic [12:0] f, input logic [4:0] e);
    return ((|f[8:0]) & e[0]) | (f[9] & e[1]) | (f[10] & e[2]) | (f[11] & e[3]) | (f[12] & e[4]);
  endfunction

  function automatic logic [18:0] img(input logic [12:0] f, input logic [4:0] e, input logic fx);
    return {fx, e, f};
  endfunction

  task automatic check1(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [1:0] md, input logic v, input logic ar,
                      input logic [7:0] inv, input logic zd, input logic ov, input logic ti,
                      input logic lo, input logic nx, input logic we, input logic [18:0] wd);
    logic [12:0] occ, bf, nf;
    logic [4:0]  be;
    logic        bfx, nfx, req;
    @(negedge clk);
    mode_i = md; op_valid_i = v; op_is_arith_i = ar; op_inv_i = inv;
    op_zdiv_i = zd; op_ovf_i = ov; op_tiny_i = ti; op_loss_i = lo; op_inexact_i = nx;
    sw_we_i = we; sw_wdata_i = wd;
    #1;
    // R6, R7: combinational, from enables held now
    check1("R6 suppress", suppress_o, v & (((|inv) & m_en[0]) | (zd & m_en[1])));
    check1("R7 default_nan", default_nan_o, v & ar & (|inv) & ~m_en[0]);
    occ = '0;
    if (v) begin
      occ[7:0] = inv;
      occ[9]   = zd;
      occ[10]  = ov;
      occ[11]  = ti & (m_en[3] | lo);
      occ[12]  = nx | (ov & ~m_en[2]);
    end
    bf  = we ? wd[12:0]  : m_flags;
    be  = we ? wd[17:13] : m_en;
    bfx = we ? wd[18]    : m_fx;
    nf  = bf | occ;
    nfx = bfx | (|(nf & ~m_flags));
    req = fex_of(nf, be) & ~fex_of(m_flags, m_en) & (md != 2'd0);
    q_stat.push_back({fex_of(nf, be), |nf[8:0], nfx, be, nf});
    q_req.push_back(req);
    q_tag.push_back(tag);
    m_flags = nf; m_en = be; m_fx = nfx;
  endtask

  task automatic idle(input string tag);
    step(tag, 2'd1, 1'b0, 1'b0, 8'h00, 0, 0, 0, 0, 0, 1'b0, 19'h0);
  endtask

  task automatic swr(input string tag, input logic [1:0] md, input logic [18:0] wd);
    step(tag, md, 1'b0, 1'b0, 8'h00, 0, 0, 0, 0, 0, 1'b1, wd);
  endtask

  // monitor: compares the register view after each update edge
  always @(negedge clk) begin
    if (rst_n && q_stat.size() > 0) begin
      logic [20:0] es;
      logic        er;
      string       t;
      es = q_stat.pop_front();
      er = q_req.pop_front();
      t  = q_tag.pop_front();
      vectors++;
      if (stat_o !== es) begin
        fails++;
        $display("FAIL %s stat: got %h expected %h", t, stat_o, es);
      end
      vectors++;
      if (handler_req_o !== er) begin
        fails++;
        $display("FAIL %s handler_req (R11): got %0b expected %0b", t, handler_req_o, er);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'd1; op_valid_i = 0; op_is_arith_i = 0; op_inv_i = 0;
    op_zdiv_i = 0; op_ovf_i = 0; op_tiny_i = 0; op_loss_i = 0; op_inexact_i = 0;
    sw_we_i = 0; sw_wdata_i = '0;
    m_flags = '0; m_en = '0; m_fx = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    vectors++;
    if (stat_o !== 21'h0) begin fails++; $display("FAIL R1 stat: got %h expected 0", stat_o); end
    check1("R1 handler_req", handler_req_o, 1'b0);
    rst_n = 1'b1;

    // R12: two invalid causes at once, disabled, arithmetic -> quiet NaN
    step("R12", 2'd1, 1, 1, 8'h81, 0, 0, 0, 0, 0, 0, 19'h0);
    // R3: clear summary only, then re-assert an already-set flag
    swr("R3", 2'd1, img(13'h081, 5'h00, 1'b0));
    step("R3", 2'd1, 1, 1, 8'h01, 0, 0, 0, 0, 0, 0, 19'h0);
    // R10: write merged with same-cycle inexact, new invalid enable
    step("R10", 2'd1, 1, 0, 8'h00, 0, 0, 0, 0, 1, 1, img(13'h0, 5'h01, 1'b0));
    // R11: enabled invalid compare, request fires once
    step("R11", 2'd1, 1, 0, 8'h20, 0, 0, 0, 0, 0, 0, 19'h0);
    idle("R11");
    step("R6", 2'd1, 1, 1, 8'h10, 0, 0, 0, 0, 0, 0, 19'h0);
    // R11 ignore mode: enabled zero divide gives no request
    swr("R10", 2'd0, img(13'h0, 5'h02, 1'b0));
    step("R11", 2'd0, 1, 1, 8'h00, 1, 0, 0, 0, 0, 0, 19'h0);
    idle("R2");
    idle("R2");
    // R8 underflow with enable clear then set
    swr("R8", 2'd1, img(13'h0, 5'h00, 1'b0));
    step("R8", 2'd1, 1, 1, 8'h00, 0, 0, 1, 0, 0, 0, 19'h0);
    step("R8", 2'd1, 1, 1, 8'h00, 0, 0, 1, 1, 0, 0, 19'h0);
    swr("R8", 2'd1, img(13'h0, 5'h08, 1'b0));
    step("R8", 2'd2, 1, 1, 8'h00, 0, 0, 1, 0, 0, 0, 19'h0);
    // R9 overflow with enable clear then set
    swr("R9", 2'd1, img(13'h0, 5'h00, 1'b0));
    step("R9", 2'd1, 1, 1, 8'h00, 0, 1, 0, 0, 0, 0, 19'h0);
    swr("R9", 2'd1, img(13'h0, 5'h04, 1'b0));
    step("R9", 2'd3, 1, 1, 8'h00, 0, 1, 0, 0, 0, 0, 19'h0);
    step("R12", 2'd1, 1, 1, 8'h00, 0, 1, 0, 0, 1, 0, 19'h0);
    // R4: software-requested invalid drives the summary; clearing removes it
    swr("R4", 2'd1, img(13'h100, 5'h00, 1'b0));
    swr("R4", 2'd1, img(13'h000, 5'h00, 1'b0));
    // R10: software sets overall summary alone
    swr("R10", 2'd1, img(13'h000, 5'h00, 1'b1));
    // R5: enabled summary from a software-written flag and enable
    swr("R5", 2'd1, img(13'h1000, 5'h10, 1'b0));
    idle("R5");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r, w;
      r = $urandom();
      w = $urandom();
      step("R2", r[1:0], r[2], r[3], (r[4] ? r[15:8] : 8'h00), r[16], r[17], r[18], r[19],
           r[20], (r[23:21] == 3'd0), w[18:0]);
    end
    idle("R2");
    idle("R2");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule